// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers interrupt requests for a small 8-bit core from six sources. The sources are two external pins, two timer overflow pulses, a periodic time-base tick and a real-time-clock tick. Each source has a request flag and an enable bit, and both sit in two byte-wide control registers that the core reads and writes through a simple register port. A falling edge on an external pin, or a one-cycle pulse on a timer or tick input, sets the matching flag.

Pending requests are judged only on the cycle in which the core raises its instruction-phase strobe. Anything that arrives between two strobes waits for the next one. A source is taken when all four of these hold: its flag is set, its enable is set, the master enable is set and the core's call stack is not full. When several sources qualify, the one with the lowest index wins. The controller then gives a one-cycle acknowledge carrying the source's vector address. In the same step it clears the served flag and the master enable. Return-with-enable sets the master enable again, and a plain return leaves it as it was.

A two-state machine sequences the grant. The states are `S_WAIT` (idle, watching for a strobe) and `S_ACK` (acknowledge cycle). There are two transitions. *grant* goes from `S_WAIT` to `S_ACK` on a strobe with an eligible source. *release* goes from `S_ACK` back to `S_WAIT` unconditionally, one cycle later.

Top module: `vpic_top`

## Requirements
- R1: A synchronous active-high reset clears all six flags, all six enables and the master enable, and holds `irq_ack` low. After reset, both control registers read 0x00.
- R2: The control register at address 0x0B holds the following bits: bit 0 master enable; bits 1, 2 and 3 enable external 0, external 1 and timer 0; bits 4, 5 and 6 are the flags of external 0, external 1 and timer 0. The register at 0x1E holds: bits 1, 2 and 3 enable timer 1, time base and real-time clock; bits 4, 5 and 6 are their flags. Bit 7 of both registers and bit 0 of 0x1E read zero. Any other address reads 0x00, and writes to it have no effect.
- R3: A high-to-low transition on `ext_pin[k]` sets the flag of external source k at the next clock edge. A rising or steady pin sets nothing.
- R4: A high level on `tmr0_ovf`, `tmr1_ovf`, `tbase_tick` or `rtc_tick` during a cycle sets that source's flag.
- R5: Sources are judged only in a cycle where `phase_tick` is high. Pending requests cause no acknowledge while `phase_tick` stays low.
- R6: A source is taken only if its flag, its enable and the master enable are all 1 and `stack_full` is 0.
- R7: Among qualifying sources, the priority order is external 0, external 1, timer 0, timer 1, time base, real-time clock. The vectors are 0x04, 0x08, 0x0C, 0x10, 0x14 and 0x18 respectively.
- R8: `irq_ack` is high for exactly one cycle, in the cycle after the judging strobe. `irq_vector` carries the vector during that cycle and is 0x00 otherwise.
- R9: Taking a source clears its flag and the master enable. All other flags and enables keep their values.
- R10: `ret_ei` sets the master enable. `ret_plain` leaves it unchanged. A grant in the same cycle overrides `ret_ei`.
- R11: A hardware flag set outranks a register write and a grant clear of the same flag in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| phase_tick | input | 1 | Instruction-phase strobe; requests are judged in its cycle |
| ext_pin | input | 2 | External request pins, falling-edge sensitive |
| tmr0_ovf | input | 1 | Timer 0 overflow pulse |
| tmr1_ovf | input | 1 | Timer 1 overflow pulse |
| tbase_tick | input | 1 | Time-base tick pulse |
| rtc_tick | input | 1 | Real-time-clock tick pulse |
| stack_full | input | 1 | Core call stack is full; blocks service |
| reg_addr | input | 8 | Register port address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational on address) |
| ret_ei | input | 1 | Return with interrupt re-enable |
| ret_plain | input | 1 | Plain return |
| irq_ack | output | 1 | One-cycle acknowledge to the core |
| irq_vector | output | 8 | Vector address, valid with `irq_ack` |

## Verification
Two functions can act on the same flag in the same cycle: a hardware set from a pin edge, and a software write that tries to clear the flag. The bench lowers an external pin and writes zero to its flag in the same cycle. It then reads the register back and expects the flag to be set. A sweep over every combination of the six flags and six enables checks the grant path. For each combination, the bench computes the winning vector and the post-grant register contents itself, then compares them with the acknowledge and with a readback of both registers.

// File: rtl/vpic_pkg.sv
package vpic_pkg;
    localparam int NSRC        = 6;
    localparam int SRC_PER_REG = 3;
    localparam int FLAG_LSB    = 4;
    localparam int EN_LSB      = 1;
    localparam int IDX_W       = $clog2(NSRC);

    typedef enum logic {S_WAIT, S_ACK} ctl_state_t;

    // vector = 4 * (index + 1)
    function automatic logic [7:0] vec_of(input logic [IDX_W-1:0] idx);
        return 8'((32'(idx) + 1) * 4);
    endfunction
endpackage

// File: rtl/vpic_regs.sv
module vpic_regs
    import vpic_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] CTL0_ADDR = 'h0B,
    parameter logic [ADDR_W-1:0] CTL1_ADDR = 'h1E
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        ext_pin,
    input  logic [3:0]        tick,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              take,
    input  logic [IDX_W-1:0]  take_idx,
    input  logic              ret_ei,
    input  logic              ret_plain,
    output logic [NSRC-1:0]   flag_q,
    output logic [NSRC-1:0]   en_q,
    output logic              master_q
);
    logic [1:0]      ext_prev;
    logic [NSRC-1:0] hw_set;
    logic            wr_ctl0;
    logic            unused_bits;

    assign wr_ctl0     = reg_wr && (reg_addr == CTL0_ADDR);
    assign hw_set      = {tick, ext_prev & ~ext_pin};
    assign unused_bits = reg_wdata[DATA_W-1];

    always_ff @(posedge clk) begin
        if (rst) ext_prev <= '0;
        else     ext_prev <= ext_pin;
    end

    always_ff @(posedge clk) begin
        if (rst)            master_q <= 1'b0;
        else if (take)      master_q <= 1'b0;
        else if (ret_ei)    master_q <= 1'b1;
        else if (ret_plain) master_q <= master_q;
        else if (wr_ctl0)   master_q <= reg_wdata[0];
    end

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        localparam int RSEL = i / SRC_PER_REG;
        localparam int FBIT = FLAG_LSB + (i % SRC_PER_REG);
        localparam int EBIT = EN_LSB + (i % SRC_PER_REG);
        logic hit;
        assign hit = reg_wr && (reg_addr == ((RSEL == 0) ? CTL0_ADDR : CTL1_ADDR));

        always_ff @(posedge clk) begin
            if (rst)                                    flag_q[i] <= 1'b0;
            else if (hw_set[i])                         flag_q[i] <= 1'b1;
            else if (take && take_idx == IDX_W'(i))     flag_q[i] <= 1'b0;
            else if (hit)                               flag_q[i] <= reg_wdata[FBIT];
        end

        always_ff @(posedge clk) begin
            if (rst)      en_q[i] <= 1'b0;
            else if (hit) en_q[i] <= reg_wdata[EBIT];
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == CTL0_ADDR) reg_rdata[0] = master_q;
        for (int i = 0; i < NSRC; i++) begin
            if (((i / SRC_PER_REG) == 0 && reg_addr == CTL0_ADDR) ||
                ((i / SRC_PER_REG) == 1 && reg_addr == CTL1_ADDR)) begin
                reg_rdata[FLAG_LSB + (i % SRC_PER_REG)] = flag_q[i];
                reg_rdata[EN_LSB + (i % SRC_PER_REG)]   = en_q[i];
            end
        end
    end
endmodule

// File: rtl/vpic_arbiter.sv
module vpic_arbiter
    import vpic_pkg::*;
(
    input  logic [NSRC-1:0]  req,
    output logic             found,
    output logic [IDX_W-1:0] win
);
    // lowest index has the highest priority
    always_comb begin
        found = 1'b0;
        win   = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                win   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/vpic_top.sv
module vpic_top
    import vpic_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] CTL0_ADDR = 'h0B,
    parameter logic [ADDR_W-1:0] CTL1_ADDR = 'h1E
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              phase_tick,
    input  logic [1:0]        ext_pin,
    input  logic              tmr0_ovf,
    input  logic              tmr1_ovf,
    input  logic              tbase_tick,
    input  logic              rtc_tick,
    input  logic              stack_full,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              ret_ei,
    input  logic              ret_plain,
    output logic              irq_ack,
    output logic [7:0]        irq_vector
);
    ctl_state_t       state_q;
    logic [IDX_W-1:0] sel_q;
    logic [NSRC-1:0]  flag_q, en_q, eligible;
    logic             master_q, found, take;
    logic [IDX_W-1:0] win;

    assign eligible = flag_q & en_q & {NSRC{master_q & ~stack_full}};
    assign take     = (state_q == S_WAIT) && phase_tick && found;

    vpic_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .CTL0_ADDR(CTL0_ADDR), .CTL1_ADDR(CTL1_ADDR)
    ) u_regs (
        .clk(clk), .rst(rst), .ext_pin(ext_pin),
        .tick({rtc_tick, tbase_tick, tmr1_ovf, tmr0_ovf}),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .take(take), .take_idx(win),
        .ret_ei(ret_ei), .ret_plain(ret_plain),
        .flag_q(flag_q), .en_q(en_q), .master_q(master_q)
    );

    vpic_arbiter u_arb (.req(eligible), .found(found), .win(win));

    // state register: grant (S_WAIT->S_ACK), release (S_ACK->S_WAIT)
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_WAIT;
            sel_q   <= '0;
        end else begin
            unique case (state_q)
                S_WAIT: if (take) begin
                    state_q <= S_ACK;
                    sel_q   <= win;
                end
                S_ACK:  state_q <= S_WAIT;
                default: state_q <= S_WAIT;
            endcase
        end
    end

    always_comb begin
        irq_ack    = 1'b0;
        irq_vector = 8'h00;
        unique case (state_q)
            S_ACK: begin
                irq_ack    = 1'b1;
                irq_vector = vec_of(sel_q);
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/vpic_chk.sv
module vpic_chk #(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] CTL0_ADDR = 'h0B
) (
    input logic              clk,
    input logic              rst,
    input logic              phase_tick,
    input logic              stack_full,
    input logic              ret_ei,
    input logic              ret_plain,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              irq_ack,
    input logic [7:0]        irq_vector,
    input logic              master
);
    assert_ack_single_R8: assert property (@(posedge clk) disable iff (rst)
        irq_ack |=> !irq_ack);

    assert_take_gated_R6: assert property (@(posedge clk) disable iff (rst)
        irq_ack |-> ($past(master) && !$past(stack_full)));

    assert_on_strobe_R5: assert property (@(posedge clk) disable iff (rst)
        irq_ack |-> $past(phase_tick));

    assert_vector_R7: assert property (@(posedge clk) disable iff (rst)
        irq_ack |-> (irq_vector[1:0] == 2'b00 && irq_vector >= 8'h04 && irq_vector <= 8'h18));

    assert_master_clr_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_ack) |-> !master);

    assert_reti_R10: assert property (@(posedge clk) disable iff (rst)
        (ret_ei && !phase_tick) |=> master);

    assert_plain_ret_R10: assert property (@(posedge clk) disable iff (rst)
        (ret_plain && !ret_ei && !phase_tick && !(reg_wr && reg_addr == CTL0_ADDR))
        |=> $stable(master));
endmodule

bind vpic_top vpic_chk #(.ADDR_W(ADDR_W), .CTL0_ADDR(CTL0_ADDR)) u_chk (
    .clk(clk), .rst(rst), .phase_tick(phase_tick), .stack_full(stack_full),
    .ret_ei(ret_ei), .ret_plain(ret_plain), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .irq_ack(irq_ack), .irq_vector(irq_vector), .master(master_q)
);

// File: tb/sim_vpic_top.sv
`timescale 1ns/1ps
module sim_vpic_top;
    localparam logic [7:0] A0 = 8'h0B;
    localparam logic [7:0] A1 = 8'h1E;

    logic clk = 1'b0;
    logic rst, phase_tick, tmr0_ovf, tmr1_ovf, tbase_tick, rtc_tick, stack_full;
    logic reg_wr, ret_ei, ret_plain, irq_ack;
    logic [1:0] ext_pin;
    logic [7:0] reg_addr, reg_wdata, reg_rdata, irq_vector;
    int n_run = 0, n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    vpic_top u0 (
        .clk(clk), .rst(rst), .phase_tick(phase_tick), .ext_pin(ext_pin),
        .tmr0_ovf(tmr0_ovf), .tmr1_ovf(tmr1_ovf), .tbase_tick(tbase_tick),
        .rtc_tick(rtc_tick), .stack_full(stack_full), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ret_ei(ret_ei), .ret_plain(ret_plain), .irq_ack(irq_ack),
        .irq_vector(irq_vector)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // drive at negedge; one-cycle write
    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] v);
        reg_addr = a;
        #0.5;
        v = reg_rdata;
    endtask

    task automatic strobe();
        phase_tick = 1'b1;
        @(negedge clk);
        phase_tick = 1'b0;
    endtask

    function automatic logic [7:0] pack0(input logic [5:0] f, input logic [5:0] e, input logic m);
        return {1'b0, f[2:0], e[2:0], m};
    endfunction
    function automatic logic [7:0] pack1(input logic [5:0] f, input logic [5:0] e);
        return {1'b0, f[5:3], e[5:3], 1'b0};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        rst = 1; phase_tick = 0; ext_pin = 2'b11; tmr0_ovf = 0; tmr1_ovf = 0;
        tbase_tick = 0; rtc_tick = 0; stack_full = 0; reg_wr = 0; reg_addr = 0;
        reg_wdata = 0; ret_ei = 0; ret_plain = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R1 reset state
        rd(A0, v); check("R1 ctl0 after reset", v, 8'h00);
        rd(A1, v); check("R1 ctl1 after reset", v, 8'h00);
        check("R1 ack low", irq_ack, 0);

        // R2 register map and reserved bits
        wr(A0, 8'hFF); rd(A0, v); check("R2 ctl0 readback", v, 8'h7F);
        wr(A1, 8'hFF); rd(A1, v); check("R2 ctl1 readback", v, 8'h7E);
        wr(8'h0C, 8'h00); rd(A0, v); check("R2 other address write ignored", v, 8'h7F);
        rd(8'h0C, v); check("R2 other address reads zero", v, 8'h00);
        wr(A0, 8'h00); wr(A1, 8'h00);
        rd(A0, v); check("R2 ctl0 cleared", v, 8'h00);

        // R3 falling edge sets flag, rising does not
        ext_pin[1] = 1'b0; @(negedge clk);
        rd(A0, v); check("R3 ext1 fall sets bit5", v, 8'h20);
        wr(A0, 8'h00);
        ext_pin[1] = 1'b1; repeat (2) @(negedge clk);
        rd(A0, v); check("R3 rising edge no set", v, 8'h00);

        // R11 hardware set beats software clear in the same cycle
        ext_pin[0] = 1'b0; reg_wr = 1; reg_addr = A0; reg_wdata = 8'h00;
        @(negedge clk); reg_wr = 0;
        rd(A0, v); check("R11 hw set over write", v, 8'h10);
        ext_pin[0] = 1'b1; wr(A0, 8'h00);

        // R4 timer and tick pulses
        tmr0_ovf = 1; @(negedge clk); tmr0_ovf = 0;
        rd(A0, v); check("R4 timer0 flag", v, 8'h40);
        tmr1_ovf = 1; @(negedge clk); tmr1_ovf = 0;
        rd(A1, v); check("R4 timer1 flag", v, 8'h10);
        tbase_tick = 1; @(negedge clk); tbase_tick = 0;
        rd(A1, v); check("R4 time-base flag", v, 8'h30);
        rtc_tick = 1; @(negedge clk); rtc_tick = 0;
        rd(A1, v); check("R4 rtc flag", v, 8'h70);
        wr(A0, 8'h00); wr(A1, 8'h00);

        // R5 no judging without strobe
        wr(A0, 8'h13);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); check("R5 no ack without strobe", irq_ack, 0);
        end
        strobe();
        check("R5 ack at strobe", irq_ack, 1);
        check("R8 vector ext0", irq_vector, 8'h04);
        @(negedge clk); check("R8 ack single cycle", irq_ack, 0);

        // R10 returns
        ret_plain = 1; @(negedge clk); ret_plain = 0;
        rd(A0, v); check("R10 plain return keeps master 0", v[0], 0);
        ret_ei = 1; @(negedge clk); ret_ei = 0;
        rd(A0, v); check("R10 ret_ei sets master", v[0], 1);
        ret_plain = 1; @(negedge clk); ret_plain = 0;
        rd(A0, v); check("R10 plain return keeps master 1", v[0], 1);

        // R6 stack full and master off block service
        wr(A0, 8'h13); stack_full = 1; strobe();
        check("R6 stack full blocks", irq_ack, 0);
        rd(A0, v); check("R6 flag kept when blocked", v, 8'h13);
        stack_full = 0;
        wr(A0, 8'h12); strobe();
        check("R6 master off blocks", irq_ack, 0);
        wr(A0, 8'h00);

        // R7 R8 R9 sweep over all flag and enable patterns
        for (int f = 0; f < 64; f++) begin
            for (int e = 0; e < 64; e++) begin
                logic [5:0] fl, en, w, fexp;
                int idx;
                fl = 6'(f); en = 6'(e); w = fl & en; idx = -1;
                for (int i = 5; i >= 0; i--) if (w[i]) idx = i;
                wr(A0, pack0(fl, en, 1'b1));
                wr(A1, pack1(fl, en));
                strobe();
                fexp = fl;
                if (idx >= 0) begin
                    fexp[idx] = 1'b0;
                    check("R7 ack for winner", irq_ack, 1);
                    check("R7 vector of winner", irq_vector, 32'((idx + 1) * 4));
                    rd(A0, v); check("R9 ctl0 after grant", v, pack0(fexp, en, 1'b0));
                    rd(A1, v); check("R9 ctl1 after grant", v, pack1(fexp, en));
                end else begin
                    check("R6 no ack when nothing qualifies", irq_ack, 0);
                    rd(A0, v); check("R6 ctl0 unchanged", v, pack0(fl, en, 1'b1));
                end
                @(negedge clk);
                check("R8 ack returns low", irq_ack, 0);
                check("R8 vector zero when idle", irq_vector, 0);
            end
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule